// File: doc/BRIEF.md
# Virtual-Channel Link Transmitter with Priority Command Insertion

This block feeds a 32-bit unidirectional link from three packet queues: posted requests (channel 0), non-posted requests (channel 1) and responses (channel 2). Every clock it drives one word onto the link together with a single qualifier line. The qualifier is high for command words and idle words and low for payload words. A packet is a header of one or two command words, optionally followed by 1 to 16 payload words. The first header word carries the packet's shape: bit 7 set means a second header word follows, bit 6 set means a payload follows, and bits 11:8 hold the payload length in words minus one. All three fields are captured when that header word is accepted.

Whole packets are granted round-robin across the channels. Once a payload has started, no other queue is served until its last word has gone out. A separate priority port offers dataless two-word request commands. At a packet boundary such a command wins over every queue. While a payload is in flight, the command is slipped in between two payload words, and the payload then carries on from the word where it stopped. Every queue and the priority port use valid/ready handshakes. A word accepted at a clock edge appears on the link registers at that same edge.

Top module: `linkTx`

## Requirements
- R1: After reset, and in any cycle where nothing was accepted in the previous cycle and no command half is pending, the link carries the idle word: data all zero with the qualifier high. No ready is raised while nothing is valid.
- R2: Each header word appears on the link exactly as accepted, with the qualifier high, one cycle after its handshake. A header with bit 7 clear is one word long; a header with bit 7 set is two words long.
- R3: A header with bit 6 set is followed by exactly (bits 11:8) + 1 payload words, in queue order, each with the qualifier low. A header with bit 6 clear is followed by no payload.
- R4: Packets are granted round-robin in the order channel 0, 1, 2. After reset the search starts at channel 0, and each later search starts at the channel after the one last granted, skipping channels that are not valid.
- R5: At most one source is accepted per cycle. While a packet is being sent, only its own channel (or the priority port, per R6) is served, so the packet's words stay together on the link.
- R6: A priority command accepted during a payload is sent as its low 32 bits, then its high 32 bits, both with the qualifier high, in two consecutive cycles. The payload then resumes with the next unsent word, and no word is lost or repeated.
- R7: An insertion happens only after at least one payload word has been sent. At most one insertion falls in each 4-word segment of the payload, where the segment is (index of the last payload word sent) divided by 4.
- R8: At a packet boundary a valid priority command is sent before any queued packet, and back-to-back pending commands are sent in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| qValid | input | NUM_CH | Per-channel word valid |
| qWord | input | NUM_CH x WORD_W | Per-channel word (header or payload) |
| qReady | output | NUM_CH | Per-channel word accepted |
| priValid | input | 1 | Priority command valid |
| priCmd | input | 2 x WORD_W | Priority command, low word sent first |
| priReady | output | 1 | Priority command accepted |
| linkData | output | WORD_W | Link data word |
| linkCtl | output | 1 | Link qualifier: high for command and idle words |

## Verification
The assertions assume that a priority command always has bit 7 set and bit 6 clear, which makes it a dataless two-word request. They also assume that a command, once offered, stays valid and unchanged until it is taken. Both stimulus sources come from bench queues that present the head entry until its handshake. Every priority command the bench builds has that fixed shape. Each queue packet is pushed whole, so a channel never runs dry partway through a packet. Priority commands meant to land inside a payload are released only once the packet's header has been taken, so that every insertion point can be computed from the payload length alone.

// File: rtl/linkTxPkg.sv
package linkTxPkg;
  localparam int MAX_PAY_WORDS = 16;
  localparam int LEN_W = $clog2(MAX_PAY_WORDS);
  localparam int HDR_LONG_BIT = 7;
  localparam int HDR_DATA_BIT = 6;
  localparam int HDR_LEN_LSB = 8;

  typedef enum logic [1:0] {SRC_NOP, SRC_QUEUE, SRC_PRI_LO, SRC_PRI_HI} srcSel_e;
  typedef enum logic [1:0] {ST_HDR, ST_HDR2, ST_PAY, ST_INS} txState_e;

  typedef struct packed {
    srcSel_e src;
    logic    ctlBit;
    logic    loadHi;
  } dpStrobe_t;

  typedef struct packed {
    logic             isLong;
    logic             hasData;
    logic [LEN_W-1:0] lenM1;
  } hdrInfo_t;
endpackage

// File: rtl/linkTxArb.sv
module linkTxArb #(
  parameter int NUM_CH = 3,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic [NUM_CH-1:0] req,
  input  logic [CH_W-1:0]   lastIdx,
  output logic              grantValid,
  output logic [CH_W-1:0]   grantIdx
);
  // Search from farthest to nearest so the nearest requester after lastIdx wins.
  always_comb begin
    grantValid = 1'b0;
    grantIdx   = '0;
    for (int k = NUM_CH; k >= 1; k--) begin
      int idx;
      idx = (int'(lastIdx) + k) % NUM_CH;
      if (req[idx]) begin
        grantValid = 1'b1;
        grantIdx   = CH_W'(idx);
      end
    end
  end
endmodule

// File: rtl/linkTxCtrl.sv
module linkTxCtrl
  import linkTxPkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int SEG_WORDS = 4,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int SEG_SHIFT = $clog2(SEG_WORDS),
  localparam int SEG_W = (LEN_W > SEG_SHIFT) ? (LEN_W - SEG_SHIFT) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] qValid,
  input  logic              priValid,
  input  hdrInfo_t          hdr,
  output logic [NUM_CH-1:0] qReady,
  output logic              priReady,
  output logic [CH_W-1:0]   chSel,
  output dpStrobe_t         strobe
);
  txState_e         state, stateN;
  logic [CH_W-1:0]  curCh, curChN, lastCh, lastChN;
  logic             hasDataR, hasDataN, retPay, retPayN;
  logic [LEN_W-1:0] lenM1R, lenM1N, cnt, cntN, cntM1;
  logic             insUsed, insUsedN;
  logic [SEG_W-1:0] insSeg, insSegN, curSeg;
  logic             grantValid, canIns;
  logic [CH_W-1:0]  grantIdx;

  linkTxArb #(.NUM_CH(NUM_CH)) uArb (
    .req(qValid), .lastIdx(lastCh), .grantValid(grantValid), .grantIdx(grantIdx)
  );

  always_comb begin
    cntM1  = cnt - 1'b1;
    curSeg = SEG_W'(cntM1 >> SEG_SHIFT);
    canIns = (cnt != '0) && !(insUsed && (insSeg == curSeg));
    chSel  = (state == ST_HDR) ? grantIdx : curCh;
  end

  always_comb begin
    qReady   = '0;
    priReady = 1'b0;
    strobe   = '{src: SRC_NOP, ctlBit: 1'b1, loadHi: 1'b0};
    stateN   = state;
    curChN   = curCh;
    lastChN  = lastCh;
    hasDataN = hasDataR;
    lenM1N   = lenM1R;
    cntN     = cnt;
    insUsedN = insUsed;
    insSegN  = insSeg;
    retPayN  = retPay;
    unique case (state)
      ST_HDR: begin
        if (priValid) begin
          priReady = 1'b1;
          strobe   = '{src: SRC_PRI_LO, ctlBit: 1'b1, loadHi: 1'b1};
          retPayN  = 1'b0;
          stateN   = ST_INS;
        end else if (grantValid) begin
          qReady[grantIdx] = 1'b1;
          strobe   = '{src: SRC_QUEUE, ctlBit: 1'b1, loadHi: 1'b0};
          curChN   = grantIdx;
          lastChN  = grantIdx;
          hasDataN = hdr.hasData;
          lenM1N   = hdr.lenM1;
          cntN     = '0;
          insUsedN = 1'b0;
          if (hdr.isLong)       stateN = ST_HDR2;
          else if (hdr.hasData) stateN = ST_PAY;
        end
      end
      ST_HDR2: begin
        if (qValid[curCh]) begin
          qReady[curCh] = 1'b1;
          strobe = '{src: SRC_QUEUE, ctlBit: 1'b1, loadHi: 1'b0};
          stateN = hasDataR ? ST_PAY : ST_HDR;
        end
      end
      ST_PAY: begin
        if (canIns && priValid) begin
          priReady = 1'b1;
          strobe   = '{src: SRC_PRI_LO, ctlBit: 1'b1, loadHi: 1'b1};
          retPayN  = 1'b1;
          insUsedN = 1'b1;
          insSegN  = curSeg;
          stateN   = ST_INS;
        end else if (qValid[curCh]) begin
          qReady[curCh] = 1'b1;
          strobe = '{src: SRC_QUEUE, ctlBit: 1'b0, loadHi: 1'b0};
          cntN   = cnt + 1'b1;
          if (cnt == lenM1R) stateN = ST_HDR;
        end
      end
      ST_INS: begin
        strobe = '{src: SRC_PRI_HI, ctlBit: 1'b1, loadHi: 1'b0};
        stateN = retPay ? ST_PAY : ST_HDR;
      end
      default: stateN = ST_HDR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_HDR;
      curCh    <= '0;
      lastCh   <= CH_W'(NUM_CH - 1);
      hasDataR <= 1'b0;
      lenM1R   <= '0;
      cnt      <= '0;
      insUsed  <= 1'b0;
      insSeg   <= '0;
      retPay   <= 1'b0;
    end else begin
      state    <= stateN;
      curCh    <= curChN;
      lastCh   <= lastChN;
      hasDataR <= hasDataN;
      lenM1R   <= lenM1N;
      cnt      <= cntN;
      insUsed  <= insUsedN;
      insSeg   <= insSegN;
      retPay   <= retPayN;
    end
  end
endmodule

// File: rtl/linkTxDp.sv
module linkTxDp
  import linkTxPkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int WORD_W = 32,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [NUM_CH-1:0][WORD_W-1:0]  qWord,
  input  logic [2*WORD_W-1:0]            priCmd,
  input  logic [CH_W-1:0]                chSel,
  input  dpStrobe_t                      strobe,
  output hdrInfo_t                       hdr,
  output logic [WORD_W-1:0]              linkData,
  output logic                           linkCtl
);
  logic [WORD_W-1:0] curWord, hiHold;

  always_comb begin
    curWord     = qWord[chSel];
    hdr.isLong  = curWord[HDR_LONG_BIT];
    hdr.hasData = curWord[HDR_DATA_BIT];
    hdr.lenM1   = curWord[HDR_LEN_LSB +: LEN_W];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      linkData <= '0;
      linkCtl  <= 1'b1;
      hiHold   <= '0;
    end else begin
      unique case (strobe.src)
        SRC_QUEUE:  linkData <= curWord;
        SRC_PRI_LO: linkData <= priCmd[WORD_W-1:0];
        SRC_PRI_HI: linkData <= hiHold;
        default:    linkData <= '0;
      endcase
      linkCtl <= strobe.ctlBit;
      if (strobe.loadHi) hiHold <= priCmd[2*WORD_W-1:WORD_W];
    end
  end
endmodule

// File: rtl/linkTx.sv
module linkTx
  import linkTxPkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int WORD_W = 32,
  parameter int SEG_WORDS = 4,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_CH-1:0]             qValid,
  input  logic [NUM_CH-1:0][WORD_W-1:0] qWord,
  output logic [NUM_CH-1:0]             qReady,
  input  logic                          priValid,
  input  logic [2*WORD_W-1:0]           priCmd,
  output logic                          priReady,
  output logic [WORD_W-1:0]             linkData,
  output logic                          linkCtl
);
  dpStrobe_t       strobe;
  hdrInfo_t        hdr;
  logic [CH_W-1:0] chSel;

  linkTxCtrl #(.NUM_CH(NUM_CH), .SEG_WORDS(SEG_WORDS)) uCtrl (
    .clk(clk), .rstN(rstN), .qValid(qValid), .priValid(priValid), .hdr(hdr),
    .qReady(qReady), .priReady(priReady), .chSel(chSel), .strobe(strobe)
  );

  linkTxDp #(.NUM_CH(NUM_CH), .WORD_W(WORD_W)) uDp (
    .clk(clk), .rstN(rstN), .qWord(qWord), .priCmd(priCmd), .chSel(chSel),
    .strobe(strobe), .hdr(hdr), .linkData(linkData), .linkCtl(linkCtl)
  );
endmodule

// File: rtl/linkTxChecker.sv
module linkTxChecker
  import linkTxPkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int WORD_W = 32
) (
  input logic                          clk,
  input logic                          rstN,
  input logic [NUM_CH-1:0]             qValid,
  input logic [NUM_CH-1:0][WORD_W-1:0] qWord,
  input logic [NUM_CH-1:0]             qReady,
  input logic                          priValid,
  input logic [2*WORD_W-1:0]           priCmd,
  input logic                          priReady,
  input logic [WORD_W-1:0]             linkData,
  input logic                          linkCtl
);
  logic priTake, anyQTake, priTakeD;
  assign priTake  = priValid && priReady;
  assign anyQTake = |(qValid & qReady);

  always_ff @(posedge clk) begin
    if (!rstN) priTakeD <= 1'b0;
    else       priTakeD <= priTake;
  end

  // Input assumption: priority commands are dataless two-word requests.
  a_in_pri_shape: assert property (@(posedge clk) disable iff (!rstN)
    priValid |-> (priCmd[HDR_LONG_BIT] && !priCmd[HDR_DATA_BIT]));

  // Input assumption: an offered command is held until taken.
  a_in_pri_hold: assert property (@(posedge clk) disable iff (!rstN)
    (priValid && !priReady) |=> (priValid && $stable(priCmd)));

  // R1: nothing accepted and no pending high half -> idle word next cycle
  a_r1_idle_nop: assert property (@(posedge clk) disable iff (!rstN)
    (!anyQTake && !priTake && !priTakeD) |=> (linkCtl && linkData == '0));

  // R5: one source per cycle
  a_r5_one_source: assert property (@(posedge clk) disable iff (!rstN)
    $countones({qValid & qReady, priTake}) <= 1);

  // R6: command halves go out low then high, qualifier high
  a_r6_pri_pair: assert property (@(posedge clk) disable iff (!rstN)
    priTake |=> (linkCtl && linkData == $past(priCmd[WORD_W-1:0]))
                ##1 (linkCtl && linkData == $past(priCmd[2*WORD_W-1:WORD_W], 2)));

  // R7: no second command taken in the cycle right after one was taken
  a_r7_no_back_to_back: assert property (@(posedge clk) disable iff (!rstN)
    priTake |=> !priReady);

  for (genvar c = 0; c < NUM_CH; c++) begin : gChan
    // R2: accepted queue word is what appears on the link next cycle
    a_r2_queue_word: assert property (@(posedge clk) disable iff (!rstN)
      (qValid[c] && qReady[c]) |=> (linkData == $past(qWord[c])));
  end
endmodule

bind linkTx linkTxChecker #(.NUM_CH(NUM_CH), .WORD_W(WORD_W)) uChk (
  .clk(clk), .rstN(rstN), .qValid(qValid), .qWord(qWord), .qReady(qReady),
  .priValid(priValid), .priCmd(priCmd), .priReady(priReady),
  .linkData(linkData), .linkCtl(linkCtl)
);

// File: tb/tb_linkTx.sv
`timescale 1ns/1ps
module tb_linkTx;
  localparam int NUM_CH = 3;
  localparam int W = 32;
  localparam int NPRI = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NUM_CH-1:0] qValid = '0, qReady;
  logic [NUM_CH-1:0][W-1:0] qWord = '0;
  logic priValid = 1'b0, priReady;
  logic [2*W-1:0] priCmd = '0;
  logic [W-1:0] linkData;
  logic linkCtl;

  always #2.5 clk = ~clk;

  linkTx dut (
    .clk(clk), .rstN(rstN), .qValid(qValid), .qWord(qWord), .qReady(qReady),
    .priValid(priValid), .priCmd(priCmd), .priReady(priReady),
    .linkData(linkData), .linkCtl(linkCtl)
  );

  logic [W-1:0]   srcQ [NUM_CH][$];
  logic [2*W-1:0] priQ [$];
  logic [W:0]     expQ [$];
  logic [W:0]     actQ [$];
  logic [NUM_CH-1:0] qHs = '0;
  logic priHs = 1'b0;
  int compared = 0, mismatched = 0;
  int armCh = 0, armLen = 0, armBase = 0;
  bit armOn = 0;

  always @(posedge clk) begin
    qHs   <= qValid & qReady;
    priHs <= priValid & priReady;
  end

  function automatic logic [W-1:0] mkHdr0(int ch, int pk, bit lng, bit dat, int len);
    logic [3:0] lm1;
    lm1 = dat ? 4'(len - 1) : 4'h0;
    return {4'hC, 4'(ch), 8'(pk), 4'h0, lm1, lng, dat, 6'h15};
  endfunction
  function automatic logic [W-1:0] mkHdr1(int ch, int pk);
    return {8'hD1, 4'(ch), 4'h0, 8'(pk), 8'h3C};
  endfunction
  function automatic logic [W-1:0] mkPay(int ch, int pk, int i);
    return {4'hE, 4'(ch), 8'(pk), 8'(i), 8'h00};
  endfunction
  function automatic logic [2*W-1:0] mkPri(int n);
    return {8'hB1, 8'(n), 16'h7777, 8'hB0, 8'(n), 8'h00, 1'b1, 1'b0, 6'h2A};
  endfunction

  task automatic pushPkt(int ch, int pk, bit lng, bit dat, int len);
    srcQ[ch].push_back(mkHdr0(ch, pk, lng, dat, len));
    if (lng) srcQ[ch].push_back(mkHdr1(ch, pk));
    if (dat) for (int i = 0; i < len; i++) srcQ[ch].push_back(mkPay(ch, pk, i));
  endtask

  task automatic expPkt(int ch, int pk, bit lng, bit dat, int len);
    expQ.push_back({1'b1, mkHdr0(ch, pk, lng, dat, len)});
    if (lng) expQ.push_back({1'b1, mkHdr1(ch, pk)});
    if (dat) for (int i = 0; i < len; i++) expQ.push_back({1'b0, mkPay(ch, pk, i)});
  endtask

  task automatic expPri(int n);
    logic [2*W-1:0] c;
    c = mkPri(n);
    expQ.push_back({1'b1, c[W-1:0]});
    expQ.push_back({1'b1, c[2*W-1:W]});
  endtask

  task automatic serviceTick();
    for (int c = 0; c < NUM_CH; c++)
      if (qHs[c] && srcQ[c].size() > 0) void'(srcQ[c].pop_front());
    if (priHs && priQ.size() > 0) void'(priQ.pop_front());
    if (armOn && srcQ[armCh].size() == armLen) begin
      for (int k = 0; k < NPRI; k++) priQ.push_back(mkPri(armBase + k));
      armOn = 0;
    end
    for (int c = 0; c < NUM_CH; c++) begin
      qValid[c] = (srcQ[c].size() > 0);
      qWord[c]  = (srcQ[c].size() > 0) ? srcQ[c][0] : '0;
    end
    priValid = (priQ.size() > 0);
    priCmd   = (priQ.size() > 0) ? priQ[0] : '0;
    if (rstN && !(linkCtl && linkData == '0)) actQ.push_back({linkCtl, linkData});
  endtask

  task automatic check(string req, logic [63:0] got, logic [63:0] exp, string what);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic compareStream(string req);
    int waitCyc = 0;
    while (actQ.size() < expQ.size() && waitCyc < 600) begin
      @(negedge clk);
      waitCyc++;
    end
    repeat (8) @(negedge clk);
    check(req, 64'(actQ.size()), 64'(expQ.size()), "stream length");
    for (int i = 0; i < expQ.size() && i < actQ.size(); i++)
      check(req, 64'(actQ[i]), 64'(expQ[i]), $sformatf("word %0d {ctl,data}", i));
    actQ.delete();
    expQ.delete();
  endtask

  initial begin
    forever begin
      @(negedge clk);
      serviceTick();
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    check("R1", 64'({linkCtl, linkData}), 64'({1'b1, 32'h0}), "link during reset");
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", 64'({linkCtl, linkData}), 64'({1'b1, 32'h0}), "idle link after reset");
    check("R1", 64'({qReady, priReady}), 64'h0, "readies while idle");

    // R4 R3 R2 R5: all channels loaded at once, mixed shapes
    pushPkt(0, 1, 1, 1, 3);  pushPkt(0, 2, 1, 0, 0);
    pushPkt(1, 3, 1, 1, 16); pushPkt(1, 4, 1, 1, 1);
    pushPkt(2, 5, 0, 1, 4);  pushPkt(2, 6, 0, 0, 0);
    expPkt(0, 1, 1, 1, 3);  expPkt(1, 3, 1, 1, 16); expPkt(2, 5, 0, 1, 4);
    expPkt(0, 2, 1, 0, 0);  expPkt(1, 4, 1, 1, 1);  expPkt(2, 6, 0, 0, 0);
    compareStream("R4 R3 R2 R5 round-robin 0-1-2");

    // R4: channel 1 idle, pointer continues after channel 2
    pushPkt(0, 7, 1, 1, 2); pushPkt(0, 8, 0, 1, 5);
    pushPkt(2, 9, 0, 1, 1); pushPkt(2, 10, 1, 1, 7);
    expPkt(0, 7, 1, 1, 2);  expPkt(2, 9, 0, 1, 1);
    expPkt(0, 8, 0, 1, 5);  expPkt(2, 10, 1, 1, 7);
    compareStream("R4 skip idle channel");

    // R8: commands offered together with a queued packet go first
    pushPkt(1, 11, 1, 1, 6);
    priQ.push_back(mkPri(200)); priQ.push_back(mkPri(201));
    expPri(200); expPri(201); expPkt(1, 11, 1, 1, 6);
    compareStream("R8 command before packet");

    // R6 R7 R8: sweep payload length 1..16 with commands released after header
    for (int len = 1; len <= 16; len++) begin
      int ch, n;
      bit lng;
      ch = len % NUM_CH;
      lng = (ch != 2);
      n = 0;
      armCh = ch; armLen = len; armBase = len * 8;
      armOn = 1;
      pushPkt(ch, 20 + len, lng, 1, len);
      expQ.push_back({1'b1, mkHdr0(ch, 20 + len, lng, 1, len)});
      if (lng) expQ.push_back({1'b1, mkHdr1(ch, 20 + len)});
      for (int i = 0; i < len; i++) begin
        expQ.push_back({1'b0, mkPay(ch, 20 + len, i)});
        if ((i % 4 == 0) && (i + 1 < len) && (n < NPRI)) begin
          expPri(armBase + n);
          n++;
        end
      end
      while (n < NPRI) begin
        expPri(armBase + n);
        n++;
      end
      compareStream($sformatf("R6 R7 insertion len %0d", len));
    end

    // R1: idle again once all traffic drained
    repeat (3) @(negedge clk);
    check("R1", 64'({linkCtl, linkData}), 64'({1'b1, 32'h0}), "idle link at end");
    check("R1", 64'({qReady, priReady}), 64'h0, "readies at end");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule